// File: doc/BRIEF.md
# Dual-Register Serial Discrete-Input Port

This block is a serial slave port, compatible with SPI mode 0, that exposes two shift registers through one set of pins. A register-select input picks the target. The first target is an eight-bit capture register: it takes a parallel snapshot of the synchronized discrete input bits when chip-select falls, and then shifts that snapshot out serially. The second target is a nine-bit configuration shift register. It accepts a serial write and moves its contents into a parallel configuration latch only when chip-select rises.

Eight latched bits choose the sensing mode of each channel. The ninth bit is a self-test enable flag. All pin inputs are sampled against a faster system clock, and edges of the serial clock and chip-select are detected internally. Several blocks can be chained: each serial output feeds the next serial input, and the chip-select, select and clock lines are shared.

Top module: `disc_spi_port`

## Requirements
- R1: Asynchronous reset clears the capture register, the configuration shift register and the configuration latch to zero. After reset `cfg_mode_o`, `cfg_test_o` and `sdo_oe_o` are all 0.
- R2: With `sel_i`=1 (capture register), a falling edge of `cs_ni` copies `din_i` into the capture register, with low reading as 0 and high as 1. `sdo_o` then presents channel 8 (`din_i[7]`) before any clock.
- R3: During a capture read, each `sclk_i` rising edge moves bit n to bit n+1 and loads `sdi_i` into bit 1. `sdo_o` therefore gives channels 8 down to 1, and the `sdi_i` bits reappear on `sdo_o` after 8 clocks.
- R4: While `cs_ni` is high, `sdo_oe_o` is 0 and `sclk_i` edges leave both shift registers unchanged.
- R5: With `sel_i`=0, nine clocks shift a word in with bit 9 first. `cfg_mode_o` and `cfg_test_o` keep their old value until `cs_ni` rises, and then take the shifted word.
- R6: Configuration bit n (n=1..8) drives `cfg_mode_o[n-1]`, where 1 selects ground/open sensing with pull-up and 0 selects 28V/open sensing with pull-down. Bit 9 drives `cfg_test_o`, where 1 enables self-test. During a write, `sdo_o` shows the present configuration shift register contents, bit 9 first.
- R7: Clocks during a capture read do not alter the configuration shift register. A `cs_ni` rise with `sel_i`=1 does not alter the configuration latch.
- R8: With two blocks chained (first `sdo_o` into second `sdi_i`), a 16-clock read returns the second block's channels 8..1 and then the first block's channels 8..1. An 18-clock write loads the first nine bits into the second block and the last nine into the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to sample all pins |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Chip select, active low |
| sel_i | input | 1 | Register select: 1 capture, 0 configuration |
| sclk_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data in |
| din_i | input | NCH | Discrete input bits, bit 0 is channel 1 |
| sdo_o | output | 1 | Serial data out (valid when enabled) |
| sdo_oe_o | output | 1 | Output enable for the tri-state serial data out |
| cfg_mode_o | output | NCH | Latched per-channel mode bits |
| cfg_test_o | output | 1 | Latched self-test enable |

## Verification
The case that is hardest to reach from the ports is proving that a register was left untouched: clocks while deselected, clocks aimed at the other register, and a deselect edge with the capture register chosen. The port has no direct read of the configuration shift register. The stimulus therefore opens a later configuration write and samples `sdo_o` on each of its nine clocks, which reads the shift register's present contents and exposes any stray shift. The two-block chain is built in the bench by wiring the first block's serial output to the second's input, so that pass-through delay and write ordering are observed end to end.

// File: rtl/disc_spi_pkg.sv
package disc_spi_pkg;
  localparam int DEF_NCH = 8;

  typedef enum logic {
    SEL_CFG  = 1'b0,
    SEL_DATA = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/disc_sync.sv
module disc_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) st_q[i] <= RST_VAL;
    end else begin
      st_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) st_q[i] <= st_q[i-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/disc_capture_reg.sv
module disc_capture_reg #(
  parameter int NCH = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic           shift_i,
  input  logic [NCH-1:0] din_i,
  input  logic           sdi_i,
  output logic [NCH-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_o <= '0;
    else if (load_i)  q_o <= din_i;
    else if (shift_i) q_o <= {q_o[NCH-2:0], sdi_i};
  end
endmodule

// File: rtl/disc_cfg_reg.sv
module disc_cfg_reg #(
  parameter int CW = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          shift_i,
  input  logic          commit_i,
  input  logic          sdi_i,
  output logic [CW-1:0] sr_o,
  output logic [CW-1:0] latch_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_o <= '0;
    else if (shift_i) sr_o <= {sr_o[CW-2:0], sdi_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       latch_o <= '0;
    else if (commit_i) latch_o <= sr_o;
  end
endmodule

// File: rtl/disc_spi_port.sv
module disc_spi_port
  import disc_spi_pkg::*;
#(
  parameter int NCH         = DEF_NCH,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cs_ni,
  input  logic           sel_i,
  input  logic           sclk_i,
  input  logic           sdi_i,
  input  logic [NCH-1:0] din_i,
  output logic           sdo_o,
  output logic           sdo_oe_o,
  output logic [NCH-1:0] cfg_mode_o,
  output logic           cfg_test_o
);
  localparam int CW = NCH + 1;

  // {cs, sclk, sel, sdi}: cs idles high
  logic [3:0]     ctl_s;
  logic           cs_s, sclk_s, sel_s, sdi_s;
  logic [NCH-1:0] din_s;

  disc_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1000)) u_ctl_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, sclk_i, sel_i, sdi_i}),
    .q_o   (ctl_s)
  );

  disc_sync #(.W(NCH), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_din_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (din_i),
    .q_o   (din_s)
  );

  assign {cs_s, sclk_s, sel_s, sdi_s} = ctl_s;

  logic cs_q, sclk_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q   <= 1'b1;
      sclk_q <= 1'b0;
    end else begin
      cs_q   <= cs_s;
      sclk_q <= sclk_s;
    end
  end

  reg_sel_e sel_e;
  logic     cs_fall, cs_rise, sclk_rise;

  assign sel_e     = reg_sel_e'(sel_s);
  assign cs_fall   = cs_q & ~cs_s;
  assign cs_rise   = ~cs_q & cs_s;
  assign sclk_rise = ~sclk_q & sclk_s & ~cs_s;

  logic [NCH-1:0] dr_q;
  logic [CW-1:0]  cr_q, cl_q;

  disc_capture_reg #(.NCH(NCH)) u_dreg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (cs_fall & (sel_e == SEL_DATA)),
    .shift_i(sclk_rise & (sel_e == SEL_DATA)),
    .din_i  (din_s),
    .sdi_i  (sdi_s),
    .q_o    (dr_q)
  );

  disc_cfg_reg #(.CW(CW)) u_creg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (sclk_rise & (sel_e == SEL_CFG)),
    .commit_i(cs_rise & (sel_e == SEL_CFG)),
    .sdi_i   (sdi_s),
    .sr_o    (cr_q),
    .latch_o (cl_q)
  );

  always_comb begin
    sdo_oe_o = ~cs_s;
    sdo_o    = (sel_e == SEL_DATA) ? dr_q[NCH-1] : cr_q[CW-1];
  end

  assign cfg_mode_o = cl_q[NCH-1:0];
  assign cfg_test_o = cl_q[CW-1];
endmodule

// File: rtl/disc_spi_port_chk.sv
module disc_spi_port_chk #(
  parameter int NCH = 8
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           cs_s,
  input logic           sel_s,
  input logic           sdi_s,
  input logic           cs_fall,
  input logic           cs_rise,
  input logic           sclk_rise,
  input logic [NCH-1:0] din_s,
  input logic [NCH-1:0] dr_q,
  input logic [NCH:0]   cr_q,
  input logic [NCH:0]   cl_q
);
  // R2
  capture_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_fall && sel_s) |=> (dr_q == $past(din_s)));

  // R3
  capture_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_rise && sel_s) |=> (dr_q == {$past(dr_q[NCH-2:0]), $past(sdi_s)}));

  // R4
  idle_cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_s |=> $stable(cr_q));

  // R4
  idle_capture_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_s |=> $stable(dr_q));

  // R5
  latch_only_on_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cl_q != $past(cl_q)) |-> $past(cs_rise && !sel_s));

  // R7
  cfg_isolated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_s |=> $stable(cr_q));
endmodule

bind disc_spi_port disc_spi_port_chk #(.NCH(NCH)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cs_s     (cs_s),
  .sel_s    (sel_s),
  .sdi_s    (sdi_s),
  .cs_fall  (cs_fall),
  .cs_rise  (cs_rise),
  .sclk_rise(sclk_rise),
  .din_s    (din_s),
  .dr_q     (dr_q),
  .cr_q     (cr_q),
  .cl_q     (cl_q)
);

// File: tb/disc_spi_port_bench.sv
module disc_spi_port_bench;
  localparam int NCH = 8;
  localparam int H   = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sel = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic [NCH-1:0] din_a = '0, din_b = '0;
  logic sdo_a, oe_a, sdo_b, oe_b, test_a, test_b;
  logic [NCH-1:0] mode_a, mode_b;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  disc_spi_port u_disc_spi_port (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sel_i(sel), .sclk_i(sclk),
    .sdi_i(sdi), .din_i(din_a), .sdo_o(sdo_a), .sdo_oe_o(oe_a),
    .cfg_mode_o(mode_a), .cfg_test_o(test_a)
  );

  disc_spi_port u_disc_spi_port_b (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sel_i(sel), .sclk_i(sclk),
    .sdi_i(sdo_a), .din_i(din_b), .sdo_o(sdo_b), .sdo_oe_o(oe_b),
    .cfg_mode_o(mode_b), .cfg_test_o(test_b)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_h();
    repeat (H) @(negedge clk);
  endtask

  task automatic open_cycle(input logic s);
    sel = s;
    wait_h();
    cs_n = 1'b0;
    wait_h();
  endtask

  task automatic close_cycle();
    wait_h();
    cs_n = 1'b1;
    wait_h();
  endtask

  // drive one bit, sample both outputs before the rising edge
  task automatic bit_xfer(input logic b, output logic oa, output logic ob);
    sdi = b;
    wait_h();
    oa = sdo_a;
    ob = sdo_b;
    sclk = 1'b1;
    wait_h();
    sclk = 1'b0;
  endtask

  task automatic cfg_write(input logic [NCH:0] w, output logic [NCH:0] seen);
    logic oa, ob;
    for (int i = NCH; i >= 0; i--) begin
      bit_xfer(w[i], oa, ob);
      seen[i] = oa;
    end
  endtask

  task automatic t_reset();
    check("R1 mode after reset", {24'd0, mode_a}, 32'd0);
    check("R1 test after reset", {31'd0, test_a}, 32'd0);
    check("R1 oe after reset", {31'd0, oe_a}, 32'd0);
  endtask

  task automatic t_read_single();
    logic oa, ob;
    logic [NCH-1:0] got, echo;
    logic [NCH-1:0] pat = 8'b0110_1001;
    din_a = 8'b1011_0010;
    open_cycle(1'b1);
    check("R4 oe while selected", {31'd0, oe_a}, 32'd1);
    check("R2 first bit is channel 8", {31'd0, sdo_a}, {31'd0, din_a[7]});
    for (int i = NCH - 1; i >= 0; i--) begin
      bit_xfer(pat[i], oa, ob);
      got[i] = oa;
    end
    check("R3 read order ch8..ch1", {24'd0, got}, {24'd0, din_a});
    for (int i = NCH - 1; i >= 0; i--) begin
      bit_xfer(1'b0, oa, ob);
      echo[i] = oa;
    end
    check("R3 sdi returns after 8 clocks", {24'd0, echo}, {24'd0, pat});
    close_cycle();
    check("R4 oe off after deselect", {31'd0, oe_a}, 32'd0);
  endtask

  task automatic t_read_capture_edge();
    logic oa, ob;
    logic [NCH-1:0] got;
    din_a = 8'b0100_0111;
    open_cycle(1'b1);
    din_a = 8'b1111_1111;   // change after capture must not show
    for (int i = NCH - 1; i >= 0; i--) begin
      bit_xfer(1'b0, oa, ob);
      got[i] = oa;
    end
    check("R2 capture at cs fall only", {24'd0, got}, 32'h47);
    close_cycle();
  endtask

  task automatic t_write_single(input logic [NCH:0] w, input logic [NCH:0] old);
    logic [NCH:0] seen;
    open_cycle(1'b0);
    cfg_write(w, seen);
    check("R6 sdo shows present config", {23'd0, seen}, {23'd0, old});
    wait_h();
    check("R5 mode held before cs rise", {24'd0, mode_a}, {24'd0, old[NCH-1:0]});
    check("R5 test held before cs rise", {31'd0, test_a}, {31'd0, old[NCH]});
    cs_n = 1'b1;
    wait_h();
    check("R6 mode bits after commit", {24'd0, mode_a}, {24'd0, w[NCH-1:0]});
    check("R6 test bit after commit", {31'd0, test_a}, {31'd0, w[NCH]});
  endtask

  task automatic t_ignore_idle(input logic [NCH:0] cur);
    logic [NCH:0] seen;
    sel = 1'b0;
    sdi = 1'b1;
    for (int i = 0; i < 10; i++) begin
      sclk = 1'b1; wait_h();
      sclk = 1'b0; wait_h();
      check("R4 oe stays off while deselected", {31'd0, oe_a}, 32'd0);
    end
    check("R4 latch unchanged by idle clocks", {23'd0, test_a, mode_a}, {23'd0, cur});
    open_cycle(1'b0);
    cfg_write(cur, seen);
    check("R4 shift register unchanged by idle clocks", {23'd0, seen}, {23'd0, cur});
    close_cycle();
  endtask

  task automatic t_sel_isolation(input logic [NCH:0] cur);
    logic oa, ob;
    logic [NCH:0] seen;
    open_cycle(1'b1);
    for (int i = 0; i < 12; i++) bit_xfer(~cur[i % (NCH + 1)], oa, ob);
    close_cycle();
    check("R7 latch unchanged by read cycle", {23'd0, test_a, mode_a}, {23'd0, cur});
    open_cycle(1'b0);
    cfg_write(cur, seen);
    check("R7 shift register unchanged by read", {23'd0, seen}, {23'd0, cur});
    close_cycle();
  endtask

  task automatic t_chain_read();
    logic oa, ob;
    logic [2*NCH-1:0] got;
    din_a = 8'b1100_0101;
    din_b = 8'b0011_1010;
    open_cycle(1'b1);
    for (int i = 2 * NCH - 1; i >= 0; i--) begin
      bit_xfer(1'b0, oa, ob);
      got[i] = ob;
    end
    close_cycle();
    check("R8 chain read second device first", {24'd0, got[2*NCH-1:NCH]}, {24'd0, din_b});
    check("R8 chain read first device last", {24'd0, got[NCH-1:0]}, {24'd0, din_a});
  endtask

  task automatic t_chain_write();
    logic [NCH:0] wa = 9'b1_0101_0011;
    logic [NCH:0] wb = 9'b0_1110_0110;
    logic [NCH:0] s1, s2;
    open_cycle(1'b0);
    cfg_write(wb, s1);
    cfg_write(wa, s2);
    close_cycle();
    check("R8 chain write near device", {23'd0, test_a, mode_a}, {23'd0, wa});
    check("R8 chain write far device", {23'd0, test_b, mode_b}, {23'd0, wb});
  endtask

  initial begin
    logic [NCH:0] w1 = 9'b1_1010_0110;
    logic [NCH:0] w2 = 9'b0_0101_1101;
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_read_single();
    t_read_capture_edge();
    t_write_single(w1, '0);
    t_ignore_idle(w1);
    t_write_single(w2, w1);
    t_sel_isolation(w2);
    t_chain_read();
    t_chain_write();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule